// File: doc/BRIEF.md
# SPI Master/Slave Controller with Low-Power Freeze and Deferral

This block moves 8-bit bytes over a four-wire serial link. It runs either as the clock-generating master or as a slave that follows an external clock. Data moves most significant bit first. The clock idles low, and data is sampled on the rising edge and changed on the falling edge. Software sees three registers through simple read and write strobes: control, status and data. The data register has two halves. Writes go to a transmit buffer, and reads return the last received byte. The status register holds three flags: transfer complete, transmit buffer empty and mode fault. Their OR, gated by the enable bit, drives a single interrupt request.

Two inputs model system low-power states: a wait request and a stop request. The block is in a low-power state when stop is asserted, or when wait is asserted and the halt-in-wait control bit is set.

- In master mode, the low-power state freezes the serial clock in the middle of a byte. The transfer resumes when the state ends.
- In slave mode, the shift engine keeps following the external clock. The completion flag and the copy into the receive register are held back until the state ends. They are delivered only when the transfer was already in progress as the state began. A byte clocked in entirely inside a low-power state that started while idle is dropped.

In master mode, a low level on the slave-select input, with fault detection enabled, signals another master on the bus. The block then aborts the transfer and leaves master mode.

Top module: `spi_lp_ctrl`

## Requirements
- R1: A byte exchange shifts MSB first in clock mode 0. In master mode the block drives sck_o/ss_n_o/mosi_o and samples miso_i. In slave mode it follows sck_i/ss_n_i/mosi_i and drives miso_o. The byte sent is the one loaded from the transmit buffer, and the byte received ends up in the receive register (address 2, read).
- R2: Status bit 0 (done) sets when a byte completes and its received value is delivered. It clears when status (address 1) is read while done is 1 and the data register is read after that.
- R3: After reset the control register (address 0) reads 0 and status reads 0x02, meaning only the transmit-empty flag is set.
- R4: In slave mode in a low-power state, completion sets no flag and copies no data. If the transfer was running when the state began, done sets and the byte is copied when the state ends. If the state began while idle, the byte is discarded and neither happens.
- R5: In master mode, a low-power state holds sck_o and ss_n_o unchanged in the middle of a byte. After the state ends, the byte completes with correct data in both directions.
- R6: Stop alone causes the low-power state, whatever the halt-in-wait bit (control bit 3) holds. Wait causes it only when that bit is 1, so a master transfer under wait with the bit at 0 runs to completion.
- R7: After reset, reading the data register returns 0. A slave transfer that starts with no byte written shifts out the last byte received.
- R8: irq equals the enable bit (control bit 0) ANDed with the OR of the done, transmit-empty (status bit 1) and fault (status bit 2) flags. It is 0 whenever enable is 0.
- R9: In master mode (control bit 1), with enable set and fault detection (control bit 2) set, a low ss_n_i triggers a fault. The transfer aborts, ss_n_o returns high, the master bit clears and the fault flag sets.
- R10: The fault flag clears only on a control-register write that follows a status read that saw it set. A control write with no such read leaves it set.
- R11: Transmit-empty sets at reset and when the buffered byte moves into the shifter. A data write is accepted only after a status read that saw transmit-empty set, and accepting it clears the flag. Any other data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| wait_req | input | 1 | System wait state |
| stop_req | input | 1 | System stop state |
| irq | output | 1 | Combined interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | Serial clock from an external master |
| mosi_i | input | 1 | Serial data in for slave mode |
| ss_n_i | input | 1 | Active-low select in; fault sense in master mode |
| miso_o | output | 1 | Serial data out in slave mode |

## Verification
The bench puts the slave into a stop request midway through a byte and finishes the byte inside that stop. A design that posts the flag at once would show done and new data too early, and one that drops the byte would never show them. It also enters a halt-in-wait while idle and clocks a whole byte through, which catches a design that copies the byte anyway. A master transfer is frozen by stop partway through and checked for a static clock and a correct final byte. Writes without the required status read prove that a careless clear path would leak, since the transmit flag or fault flag would drop or a transfer would start.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;

    typedef enum logic [1:0] {
        ADDR_CTL  = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // control bits 3..0
    typedef struct packed {
        logic halt_in_wait;
        logic fault_en;
        logic master;
        logic enable;
    } ctl_t;

    // status bits 2..0
    typedef struct packed {
        logic fault;
        logic tx_empty;
        logic done;
    } stat_t;

    localparam ctl_t  CTL_RESET  = '{halt_in_wait: 1'b0, fault_en: 1'b0, master: 1'b0, enable: 1'b0};
    localparam stat_t STAT_RESET = '{fault: 1'b0, tx_empty: 1'b1, done: 1'b0};

    function automatic logic low_power(input logic stop, input logic wt, input logic halt_w);
        return stop | (wt & halt_w);
    endfunction

endpackage

// File: rtl/spi_lp_sync.sv
module spi_lp_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_lp_engine.sv
module spi_lp_engine #(
    parameter int DATA_W = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              master,
    input  logic              lp,
    input  logic              abort,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ss_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              miso_i,
    output logic              take,
    output logic              deliver,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              mosi_o,
    output logic              miso_o
);
    localparam int CW   = $clog2(DATA_W + 1);
    localparam int DIVW = $clog2(HALF_DIV + 1);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     bits;
    logic [DIVW-1:0]   div;
    logic              in_bit, m_busy, sck_q, ss_q, lp_q, busy_at_entry, pend;

    wire sck_rise = sck_s & ~sck_q;
    wire sck_fall = ~sck_s & sck_q;
    wire ss_fall  = ~ss_s & ss_q;
    wire s_act    = en & ~master & ~ss_s;
    wire tick     = (div == DIVW'(HALF_DIV - 1));
    wire last_bit = (bits == CW'(DATA_W - 1));
    wire [DATA_W-1:0] next_sh = {shreg[DATA_W-2:0], in_bit};

    assign mosi_o = master ? shreg[DATA_W-1] : 1'b0;
    assign miso_o = s_act ? shreg[DATA_W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0; bits <= '0; div <= '0; in_bit <= 1'b0;
            m_busy <= 1'b0; sck_q <= 1'b0; ss_q <= 1'b1; lp_q <= 1'b0;
            busy_at_entry <= 1'b0; pend <= 1'b0;
            take <= 1'b0; deliver <= 1'b0; rx_byte <= '0;
            sck_o <= 1'b0; ss_n_o <= 1'b1;
        end else begin
            take    <= 1'b0;
            deliver <= 1'b0;
            sck_q   <= sck_s;
            ss_q    <= ss_s;
            lp_q    <= lp;
            // low-power entry / exit bookkeeping for the slave path
            if (lp && !lp_q) busy_at_entry <= s_act;
            if (!lp && lp_q) begin
                busy_at_entry <= 1'b0;
                if (pend) begin
                    deliver <= 1'b1;
                    rx_byte <= shreg;
                    pend    <= 1'b0;
                end
            end
            if (master) begin
                if (abort || !en) begin
                    m_busy <= 1'b0; sck_o <= 1'b0; ss_n_o <= 1'b1;
                    bits <= '0; div <= '0;
                end else if (!m_busy) begin
                    if (tx_full && !lp) begin
                        shreg <= tx_byte; take <= 1'b1; m_busy <= 1'b1;
                        ss_n_o <= 1'b0; div <= '0; bits <= '0; sck_o <= 1'b0;
                    end
                end else if (!lp) begin
                    if (tick) begin
                        div   <= '0;
                        sck_o <= ~sck_o;
                        if (!sck_o) begin
                            in_bit <= miso_i;
                        end else begin
                            shreg <= next_sh;
                            bits  <= bits + 1'b1;
                            if (last_bit) begin
                                m_busy <= 1'b0; ss_n_o <= 1'b1; bits <= '0;
                                deliver <= 1'b1; rx_byte <= next_sh;
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            end else begin
                m_busy <= 1'b0; sck_o <= 1'b0; ss_n_o <= 1'b1; div <= '0;
                if (!en || ss_s) begin
                    bits <= '0;
                end else if (ss_fall) begin
                    bits <= '0;
                    if (tx_full) begin
                        shreg <= tx_byte;
                        take  <= 1'b1;
                    end
                end else begin
                    if (sck_rise) in_bit <= mosi_s;
                    if (sck_fall) begin
                        shreg <= next_sh;
                        bits  <= bits + 1'b1;
                        if (last_bit) begin
                            bits <= '0;
                            if (!lp) begin
                                deliver <= 1'b1;
                                rx_byte <= next_sh;
                            end else if (busy_at_entry) begin
                                pend <= 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_lp_regs.sv
module spi_lp_regs
    import spi_lp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    input  logic              deliver,
    input  logic [DATA_W-1:0] rx_in,
    input  logic              ss_s,
    output ctl_t              ctl,
    output stat_t             st,
    output logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rdata,
    output logic              fault_evt,
    output logic              irq
);
    logic [DATA_W-1:0] rxbuf;
    logic arm_done, arm_empty, arm_fault;
    logic unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:4];
    assign fault_evt = ctl.enable & ctl.master & ctl.fault_en & ~ss_s;
    assign irq = ctl.enable & (st.done | st.tx_empty | st.fault);

    always_comb begin
        case (reg_addr_e'(addr))
            ADDR_CTL:  rdata = DATA_W'(ctl);
            ADDR_STAT: rdata = DATA_W'(st);
            ADDR_DATA: rdata = rxbuf;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET; st <= STAT_RESET;
            tx_byte <= '0; rxbuf <= '0;
            arm_done <= 1'b0; arm_empty <= 1'b0; arm_fault <= 1'b0;
        end else begin
            if (rd && addr == ADDR_STAT) begin
                arm_done  <= st.done;
                arm_empty <= st.tx_empty;
                arm_fault <= st.fault;
            end
            if (wr && addr == ADDR_CTL) begin
                ctl <= ctl_t'(wdata[3:0]);
                if (arm_fault) begin
                    st.fault  <= 1'b0;
                    arm_fault <= 1'b0;
                end
            end
            if (wr && addr == ADDR_DATA && arm_empty) begin
                tx_byte     <= wdata;
                st.tx_empty <= 1'b0;
                arm_empty   <= 1'b0;
            end
            if (rd && addr == ADDR_DATA && arm_done) begin
                st.done  <= 1'b0;
                arm_done <= 1'b0;
            end
            if (take) st.tx_empty <= 1'b1;
            if (deliver) begin
                rxbuf   <= rx_in;
                st.done <= 1'b1;
            end
            if (fault_evt) begin
                st.fault   <= 1'b1;
                ctl.master <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_lp_ctrl.sv
module spi_lp_ctrl
    import spi_lp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_DIV = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wait_req,
    input  logic              stop_req,
    output logic              irq,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              ss_n_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o
);
    ctl_t              ctl;
    stat_t             st;
    logic [2:0]        pins_s;
    logic [DATA_W-1:0] tx_byte, rx_byte;
    logic              take, deliver, fault_evt, lp;
    logic              en_w, master_w, fault_w;

    assign lp       = low_power(stop_req, wait_req, ctl.halt_in_wait);
    assign en_w     = ctl.enable;
    assign master_w = ctl.master;
    assign fault_w  = st.fault;

    spi_lp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk(clk), .rst(rst), .d({ss_n_i, sck_i, mosi_i}), .q(pins_s)
    );

    spi_lp_regs #(.DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .take(take), .deliver(deliver), .rx_in(rx_byte),
        .ss_s(pins_s[2]), .ctl(ctl), .st(st), .tx_byte(tx_byte),
        .rdata(reg_rdata), .fault_evt(fault_evt), .irq(irq)
    );

    spi_lp_engine #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) i_engine (
        .clk(clk), .rst(rst), .en(ctl.enable), .master(ctl.master), .lp(lp),
        .abort(fault_evt), .tx_full(~st.tx_empty), .tx_byte(tx_byte),
        .ss_s(pins_s[2]), .sck_s(pins_s[1]), .mosi_s(pins_s[0]), .miso_i(miso_i),
        .take(take), .deliver(deliver), .rx_byte(rx_byte),
        .sck_o(sck_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_o(miso_o)
    );
endmodule

// File: rtl/spi_lp_ctrl_chk.sv
module spi_lp_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic master,
    input logic fault,
    input logic irq,
    input logic lp,
    input logic deliver,
    input logic sck_o,
    input logic ss_n_o
);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst) !enable |-> !irq);

    // R9
    fault_drop_chk: assert property (@(posedge clk) disable iff (rst) $rose(fault) |-> !master);

    // R9
    ss_release_chk: assert property (@(posedge clk) disable iff (rst) !master |=> ss_n_o);

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (lp && $past(lp) && master && enable && $past(enable)) |-> ($stable(sck_o) && $stable(ss_n_o)));

    // R4
    defer_chk: assert property (@(posedge clk) disable iff (rst) $past(lp) |-> !deliver);
endmodule

bind spi_lp_ctrl spi_lp_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .enable(en_w), .master(master_w), .fault(fault_w),
    .irq(irq), .lp(lp), .deliver(deliver), .sck_o(sck_o), .ss_n_o(ss_n_o)
);

// File: tb/test_spi_lp_ctrl.sv
module test_spi_lp_ctrl;
    localparam int HALF = 6;

    logic clk = 0, rst = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic wait_req = 0, stop_req = 0, irq;
    logic sck_o, mosi_o, ss_n_o, miso_o;
    logic miso_i = 0, sck_i = 0, mosi_i = 0, ss_n_i = 1;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    spi_lp_ctrl i_spi_lp_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_req(wait_req),
        .stop_req(stop_req), .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o),
        .ss_n_o(ss_n_o), .miso_i(miso_i), .sck_i(sck_i), .mosi_i(mosi_i),
        .ss_n_i(ss_n_i), .miso_o(miso_o)
    );

    function automatic logic [7:0] exp_stat(input bit done, input bit empty, input bit fault);
        return {5'b0, fault, empty, done};
    endfunction

    function automatic logic [7:0] exp_ctl(input bit en, input bit mst, input bit fen, input bit halt);
        return {4'b0, halt, fen, mst, en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Master transfer; bench models the remote slave. stop_at>0 freezes at that rising edge.
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb, input int stop_at,
                               output logic [7:0] got_mosi);
        logic [7:0] v;
        int falls = 0, rises = 0, guard = 0;
        logic prev = 0, snap;
        rd(2'd1, v);
        wr(2'd2, tx);
        miso_i = sb[7];
        got_mosi = 0;
        while (ss_n_o && guard < 100) begin @(negedge clk); guard++; end
        while (!ss_n_o && guard < 2000) begin
            @(negedge clk); guard++;
            if (sck_o && !prev) begin
                got_mosi = {got_mosi[6:0], mosi_o};
                rises++;
                if (rises == stop_at) begin
                    stop_req = 1;
                    @(negedge clk); snap = sck_o;
                    for (int k = 0; k < 30; k++) begin
                        @(negedge clk);
                        if (sck_o !== snap || ss_n_o !== 1'b0) begin
                            chk(0, "R5 frozen clock", {sck_o, ss_n_o}, {snap, 1'b0});
                            break;
                        end
                    end
                    chk(1, "R5", 0, 0);
                    stop_req = 0;
                end
            end
            if (!sck_o && prev) begin
                falls++;
                if (falls < 8) miso_i = sb[7 - falls];
            end
            prev = sck_o;
        end
        idle(3);
    endtask

    // Slave transfer driven by the bench as external master. stop_at>=0 raises stop before that bit.
    task automatic slave_xfer(input logic [7:0] b, input int stop_at, output logic [7:0] got);
        got = 0;
        ss_n_i = 0; mosi_i = b[7];
        idle(HALF);
        for (int i = 0; i < 8; i++) begin
            if (i == stop_at) stop_req = 1;
            got = {got[6:0], miso_o};
            sck_i = 1;
            idle(HALF);
            sck_i = 0;
            if (i < 7) mosi_i = b[6 - i];
            idle(HALF);
        end
        idle(HALF);
        ss_n_i = 1;
        idle(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, got, tx, sb, w, z, vv, q;
        void'($urandom(32'h5eed1234));
        idle(4);
        rst = 0;
        idle(2);

        // R7 / R8 reset observations
        rd(2'd2, v); chk(v == 8'h00, "R7 rx after reset", v, 0);
        chk(irq == 1'b0, "R8 irq while disabled", irq, 0);
        rd(2'd0, v); chk(v == exp_ctl(0, 0, 0, 0), "R3 control reset", v, 0);

        wr(2'd0, exp_ctl(1, 1, 0, 0));
        idle(1);
        chk(irq == 1'b1, "R8 irq from tx_empty", irq, 1);

        // R11 unarmed data write ignored
        wr(2'd2, 8'hAA);
        idle(20);
        chk(ss_n_o == 1'b1, "R11 no transfer after ignored write", ss_n_o, 1);
        rd(2'd1, v); chk(v == exp_stat(0, 1, 0), "R3 R11 status after ignored write", v, 2);

        // R1 R2 R6 master random transfers; iteration 0 runs under wait with halt bit 0
        for (int it = 0; it < 5; it++) begin
            tx = 8'($urandom); sb = 8'($urandom);
            if (it == 0) wait_req = 1;
            master_xfer(tx, sb, 0, got);
            wait_req = 0;
            chk(got == tx, it == 0 ? "R6 mosi under wait" : "R1 master mosi", got, tx);
            rd(2'd1, v); chk(v == exp_stat(1, 1, 0), "R2 done set", v, exp_stat(1, 1, 0));
            rd(2'd2, v); chk(v == sb, "R1 master rx", v, sb);
            rd(2'd1, v); chk(v == exp_stat(0, 1, 0), "R2 done cleared", v, exp_stat(0, 1, 0));
        end

        // R5 stop freeze in master mid-byte
        tx = 8'h96; sb = 8'h3C;
        master_xfer(tx, sb, 3, got);
        chk(got == tx, "R5 mosi after freeze", got, tx);
        rd(2'd1, v);
        rd(2'd2, v); chk(v == sb, "R5 rx after freeze", v, sb);

        // R9 R10 mode fault
        wr(2'd0, exp_ctl(1, 1, 1, 0));
        rd(2'd1, v);
        wr(2'd2, 8'h5A);
        idle(12);
        chk(ss_n_o == 1'b0, "R9 transfer running", ss_n_o, 0);
        ss_n_i = 0;
        idle(6);
        chk(ss_n_o == 1'b1, "R9 ss released", ss_n_o, 1);
        rd(2'd0, v); chk(v == exp_ctl(1, 0, 1, 0), "R9 master cleared", v, exp_ctl(1, 0, 1, 0));
        ss_n_i = 1;
        idle(4);
        wr(2'd0, exp_ctl(1, 0, 1, 0));
        rd(2'd1, v); chk(v == exp_stat(0, 1, 1), "R10 unarmed write keeps fault", v, exp_stat(0, 1, 1));
        chk(irq == 1'b1, "R8 irq with fault", irq, 1);
        wr(2'd0, exp_ctl(1, 0, 0, 0));
        rd(2'd1, v); chk(v == exp_stat(0, 1, 0), "R10 fault cleared", v, exp_stat(0, 1, 0));

        // R1 slave exchange with preload
        w = 8'hC5; z = 8'h3A;
        wr(2'd2, w);
        slave_xfer(z, -1, got);
        chk(got == w, "R1 slave miso", got, w);
        rd(2'd1, v); chk(v == exp_stat(1, 1, 0), "R2 slave done", v, exp_stat(1, 1, 0));
        rd(2'd2, v); chk(v == z, "R1 slave rx", v, z);

        // R7 no preload: last received byte goes out
        vv = 8'h81;
        slave_xfer(vv, -1, got);
        chk(got == z, "R7 slave sends last rx", got, z);
        rd(2'd1, v);
        rd(2'd2, v); chk(v == vv, "R1 slave rx second", v, vv);

        // R4 deferred delivery across stop begun mid-transfer
        q = 8'h6E;
        slave_xfer(q, 3, got);
        rd(2'd1, v); chk(v == exp_stat(0, 1, 0), "R4 no flag in stop", v, exp_stat(0, 1, 0));
        rd(2'd2, v); chk(v == vv, "R4 rx held in stop", v, vv);
        stop_req = 0;
        idle(4);
        rd(2'd1, v); chk(v == exp_stat(1, 1, 0), "R4 flag after stop", v, exp_stat(1, 1, 0));
        rd(2'd2, v); chk(v == q, "R4 rx after stop", v, q);

        // R4 R6 wait entered and left while idle: byte discarded
        wr(2'd0, exp_ctl(1, 0, 0, 1));
        wait_req = 1;
        idle(5);
        slave_xfer(8'hF0, -1, got);
        wait_req = 0;
        idle(5);
        rd(2'd1, v); chk(v == exp_stat(0, 1, 0), "R4 idle wait no flag", v, exp_stat(0, 1, 0));
        rd(2'd2, v); chk(v == q, "R4 idle wait no copy", v, q);

        // R8 disable gates irq
        wr(2'd0, exp_ctl(0, 0, 0, 0));
        idle(1);
        chk(irq == 1'b0, "R8 irq gated by enable", irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule